// File: doc/BRIEF.md
# Link Receive Resynchronization Controller

This block sits on the receive side of a multi-lane serial converter link. It owns the active-low synchronization request line that goes back to the transmitter. It pulls that line low when the link has to be brought up again. There are two causes. One is a fault pulse from the lane receivers: lost code-group lock, a frame alignment fault or a lane alignment fault. The other is an explicit request from software.

Every fault is latched into a sticky status bit that software clears by writing a 1. Each status bit can drive a shared, registered interrupt line through its own enable. A global disable keeps faults out of the resynchronization path, so a link can be held up while its faults are studied, and the faults are still logged.

Software can also ask for a multiframe-clock realignment. The block first emits a one-cycle strobe that tells the timing logic to resample SYSREF. It then waits for the next SYSREF rising edge. Only after that edge does it request resynchronization.

Once a resynchronization is under way, the line is released only after the receiver reports code-group lock across a run of consecutive /K/ characters.

Top module: `rx_resync_ctrl`

## Requirements
- R1: After reset, syncN is 1, irq is 0, errStatus is 0 and sysrefResample is 0.
- R2: With hwReinitDisable low, a pulse on any of the three fault inputs drives syncN low from the cycle after the pulse.
- R3: With hwReinitDisable high, fault pulses leave syncN high, but the matching errStatus bits are still set.
- R4: The errStatus bits map as follows: bit 0 is code-group lock loss, bit 1 is frame alignment fault and bit 2 is lane alignment fault. A bit is set in the cycle after its fault pulse and stays set until it is cleared.
- R5: A 1 on statusClear[i] clears errStatus[i] in the next cycle. If a fault for bit i arrives in the same cycle as the clear, the bit stays set.
- R6: irq is a register holding the OR of errStatus & irqEnable. It follows errStatus one cycle later, and a status bit whose enable is 0 never raises it.
- R7: A swReinitReq pulse drives syncN low from the next cycle, even when hwReinitDisable is high and no fault is logged.
- R8: During a resynchronization, syncN stays low until K_NEED (default 4) /K/ characters have been received with cgsAchieved high, with no interruption. A character that arrives while cgsAchieved is low restarts the run, and a cycle without a character leaves the run unchanged. syncN rises in the cycle after the last character of the run.
- R9: A swReinitReq during an active resynchronization merges into it: the character run is not restarted.
- R10: An enabled fault during an active resynchronization restarts the character run. This holds even when the fault coincides with the character that would have finished the run.
- R11: A swRealignReq while idle produces a one-cycle sysrefResample pulse in the next cycle. syncN stays high until a SYSREF rising edge is sampled after the request, and goes low in the cycle after that edge. SYSREF that is already high when the request arrives does not count as an edge.
- R12: A swRealignReq during an active resynchronization is ignored: no strobe is issued, and no realignment is left pending for a later SYSREF edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rstN | input | 1 | Active-low synchronous reset |
| errCgsLoss | input | 1 | Pulse: code-group lock lost |
| errFrameAlign | input | 1 | Pulse: frame alignment fault |
| errLaneAlign | input | 1 | Pulse: lane alignment fault |
| swReinitReq | input | 1 | Pulse: software resynchronization request |
| swRealignReq | input | 1 | Pulse: software multiframe-clock realignment request |
| hwReinitDisable | input | 1 | Keeps faults from starting a resynchronization |
| irqEnable | input | 3 | Per-fault interrupt enables, bit order as errStatus |
| statusClear | input | 3 | Write-1-to-clear strobes for errStatus |
| kCharValid | input | 1 | A /K/ character was received this cycle |
| cgsAchieved | input | 1 | Receiver reports code-group lock |
| sysrefIn | input | 1 | Sampled SYSREF level |
| syncN | output | 1 | Active-low synchronization request to the transmitter |
| irq | output | 1 | Registered interrupt |
| errStatus | output | 3 | Sticky fault status |
| sysrefResample | output | 1 | One-cycle SYSREF resample strobe |

## Verification
Two pairs of functions can collide in one cycle.

The first pair is status logging and its clear. The bench pulses a lane alignment fault in the same cycle as a write-1 clear to that bit. It expects the bit to stay set and the interrupt to follow one cycle later.

The second pair is the end of a character run and a new fault. The bench drives the last /K/ of a run together with an enabled fault. It expects syncN to stay low, and to rise only after a complete fresh run.

A software request that lands in the middle of a run is judged against the cycle in which syncN would rise without the request.

// File: rtl/resync_pkg.sv
package resync_pkg;
  localparam int NUM_ERR   = 3;
  localparam int ERR_CGS   = 0;
  localparam int ERR_FRAME = 1;
  localparam int ERR_LANE  = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SYSREF_WAIT,
    ST_REINIT
  } linkState_t;

  typedef struct packed {
    logic inReinit;
    logic waitEdge;
  } ctrlStrobe_t;
endpackage

// File: rtl/resync_datapath.sv
module resync_datapath
  import resync_pkg::*;
#(
  parameter int K_NEED = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_ERR-1:0] errVec,
  input  logic               hwReinitDisable,
  input  logic [NUM_ERR-1:0] irqEnable,
  input  logic [NUM_ERR-1:0] statusClear,
  input  logic               kCharValid,
  input  logic               cgsAchieved,
  input  logic               sysrefIn,
  input  ctrlStrobe_t        ctrl,
  output logic [NUM_ERR-1:0] errStatus,
  output logic               irq,
  output logic               hwErr,
  output logic               kDone,
  output logic               sysrefEdge
);
  localparam int CNT_W = $clog2(K_NEED + 1);
  localparam logic [CNT_W-1:0] LAST_K = CNT_W'(K_NEED - 1);

  logic [CNT_W-1:0] kCount;
  logic             sysrefPrev;
  logic             kQual;

  // Sticky status bits: set has priority over write-1-to-clear
  for (genvar i = 0; i < NUM_ERR; i++) begin : g_status
    always_ff @(posedge clk) begin
      if (!rstN) begin
        errStatus[i] <= 1'b0;
      end else if (errVec[i]) begin
        errStatus[i] <= 1'b1;
      end else if (statusClear[i]) begin
        errStatus[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irq <= 1'b0;
    end else begin
      irq <= |(errStatus & irqEnable);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sysrefPrev <= 1'b0;
    end else begin
      sysrefPrev <= sysrefIn;
    end
  end

  assign hwErr      = (|errVec) & ~hwReinitDisable;
  assign kQual      = kCharValid & cgsAchieved;
  assign sysrefEdge = ctrl.waitEdge & sysrefIn & ~sysrefPrev;

  // Run of consecutive qualified /K/ characters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      kCount <= '0;
    end else if (!ctrl.inReinit || hwErr || (kCharValid && !cgsAchieved)) begin
      kCount <= '0;
    end else if (kQual && kCount != LAST_K) begin
      kCount <= kCount + 1'b1;
    end
  end

  assign kDone = ctrl.inReinit & kQual & ~hwErr & (kCount == LAST_K);
endmodule

// File: rtl/resync_fsm.sv
module resync_fsm
  import resync_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hwErr,
  input  logic        swReinitReq,
  input  logic        swRealignReq,
  input  logic        kDone,
  input  logic        sysrefEdge,
  output ctrlStrobe_t ctrl,
  output logic        syncN,
  output logic        sysrefResample
);
  linkState_t state, stateNext;
  logic       reinitHit;

  assign reinitHit = hwErr | swReinitReq;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (reinitHit)         stateNext = ST_REINIT;
        else if (swRealignReq) stateNext = ST_SYSREF_WAIT;
      end
      ST_SYSREF_WAIT: begin
        if (reinitHit || sysrefEdge) stateNext = ST_REINIT;
      end
      ST_REINIT: begin
        if (kDone) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state          <= ST_IDLE;
      sysrefResample <= 1'b0;
    end else begin
      state          <= stateNext;
      sysrefResample <= (state == ST_IDLE) & ~reinitHit & swRealignReq;
    end
  end

  assign syncN         = (state != ST_REINIT);
  assign ctrl.inReinit = (state == ST_REINIT);
  assign ctrl.waitEdge = (state == ST_SYSREF_WAIT);
endmodule

// File: rtl/rx_resync_ctrl.sv
module rx_resync_ctrl
  import resync_pkg::*;
#(
  parameter int K_NEED = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               errCgsLoss,
  input  logic               errFrameAlign,
  input  logic               errLaneAlign,
  input  logic               swReinitReq,
  input  logic               swRealignReq,
  input  logic               hwReinitDisable,
  input  logic [NUM_ERR-1:0] irqEnable,
  input  logic [NUM_ERR-1:0] statusClear,
  input  logic               kCharValid,
  input  logic               cgsAchieved,
  input  logic               sysrefIn,
  output logic               syncN,
  output logic               irq,
  output logic [NUM_ERR-1:0] errStatus,
  output logic               sysrefResample
);
  logic [NUM_ERR-1:0] errVec;
  ctrlStrobe_t        ctrl;
  logic               hwErr;
  logic               kDone;
  logic               sysrefEdge;

  always_comb begin
    errVec            = '0;
    errVec[ERR_CGS]   = errCgsLoss;
    errVec[ERR_FRAME] = errFrameAlign;
    errVec[ERR_LANE]  = errLaneAlign;
  end

  resync_datapath #(.K_NEED(K_NEED)) i_dp (
    .clk            (clk),
    .rstN           (rstN),
    .errVec         (errVec),
    .hwReinitDisable(hwReinitDisable),
    .irqEnable      (irqEnable),
    .statusClear    (statusClear),
    .kCharValid     (kCharValid),
    .cgsAchieved    (cgsAchieved),
    .sysrefIn       (sysrefIn),
    .ctrl           (ctrl),
    .errStatus      (errStatus),
    .irq            (irq),
    .hwErr          (hwErr),
    .kDone          (kDone),
    .sysrefEdge     (sysrefEdge)
  );

  resync_fsm i_fsm (
    .clk           (clk),
    .rstN          (rstN),
    .hwErr         (hwErr),
    .swReinitReq   (swReinitReq),
    .swRealignReq  (swRealignReq),
    .kDone         (kDone),
    .sysrefEdge    (sysrefEdge),
    .ctrl          (ctrl),
    .syncN         (syncN),
    .sysrefResample(sysrefResample)
  );
endmodule

// File: rtl/rx_resync_checker.sv
module rx_resync_checker (
  input logic       clk,
  input logic       rstN,
  input logic       errCgsLoss,
  input logic       errFrameAlign,
  input logic       errLaneAlign,
  input logic       swReinitReq,
  input logic       swRealignReq,
  input logic       hwReinitDisable,
  input logic [2:0] irqEnable,
  input logic [2:0] statusClear,
  input logic       kCharValid,
  input logic       cgsAchieved,
  input logic       sysrefIn,
  input logic       syncN,
  input logic       irq,
  input logic [2:0] errStatus,
  input logic       sysrefResample
);
  logic [2:0] faultIn;
  logic [2:0] keepMask;
  assign faultIn  = {errLaneAlign, errFrameAlign, errCgsLoss};
  assign keepMask = errStatus & ~statusClear;

  assert_sync_on_fault_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((|faultIn) && !hwReinitDisable) |=> !syncN);

  assert_disable_holds_sync_R3: assert property (@(posedge clk) disable iff (!rstN)
    (syncN && hwReinitDisable && !swReinitReq && !sysrefIn) |=> syncN);

  assert_status_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    (|faultIn) |=> ((errStatus & $past(faultIn)) == $past(faultIn)));

  assert_status_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|keepMask) |=> ((errStatus & $past(keepMask)) == $past(keepMask)));

  assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(|(errStatus & irqEnable)));

  assert_sw_request_R7: assert property (@(posedge clk) disable iff (!rstN)
    (swReinitReq && syncN) |=> !syncN);

  assert_release_on_k_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncN) |-> $past(kCharValid && cgsAchieved));

  assert_strobe_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    sysrefResample |=> !sysrefResample);

  assert_no_strobe_busy_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!syncN && swRealignReq) |=> !sysrefResample);
endmodule

bind rx_resync_ctrl rx_resync_checker u_chk (.*);

// File: tb/test_rx_resync_ctrl.sv
module test_rx_resync_ctrl;
  localparam int F_SYNC = 0;
  localparam int F_IRQ  = 1;
  localparam int F_STAT = 2;
  localparam int F_STRB = 3;

  typedef struct {
    int    cyc;
    int    fld;
    int    val;
    string req;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN;
  logic       errCgsLoss, errFrameAlign, errLaneAlign;
  logic       swReinitReq, swRealignReq, hwReinitDisable;
  logic [2:0] irqEnable, statusClear;
  logic       kCharValid, cgsAchieved, sysrefIn;
  logic       syncN, irq, sysrefResample;
  logic [2:0] errStatus;

  int       cyc = 0;
  int       total = 0;
  int       bad = 0;
  bit       done = 1'b0;
  expItem_t expQ[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rx_resync_ctrl i_rx_resync_ctrl (
    .clk(clk), .rstN(rstN),
    .errCgsLoss(errCgsLoss), .errFrameAlign(errFrameAlign), .errLaneAlign(errLaneAlign),
    .swReinitReq(swReinitReq), .swRealignReq(swRealignReq),
    .hwReinitDisable(hwReinitDisable), .irqEnable(irqEnable), .statusClear(statusClear),
    .kCharValid(kCharValid), .cgsAchieved(cgsAchieved), .sysrefIn(sysrefIn),
    .syncN(syncN), .irq(irq), .errStatus(errStatus), .sysrefResample(sysrefResample)
  );

  function automatic int fieldVal(int fld);
    case (fld)
      F_SYNC:  return int'(syncN);
      F_IRQ:   return int'(irq);
      F_STAT:  return int'(errStatus);
      default: return int'(sysrefResample);
    endcase
  endfunction

  function automatic string fieldName(int fld);
    case (fld)
      F_SYNC:  return "syncN";
      F_IRQ:   return "irq";
      F_STAT:  return "errStatus";
      default: return "sysrefResample";
    endcase
  endfunction

  task automatic judge(int fld, int val, string req);
    int act;
    act = fieldVal(fld);
    total++;
    if (act != val) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, fieldName(fld), act, val, cyc);
    end
  endtask

  // Driver side: queue an expectation dly cycles ahead
  task automatic pushExp(int dly, int fld, int val, string req);
    expQ.push_back('{cyc + dly, fld, val, req});
  endtask

  // Monitor: compare outputs at the falling edge
  always @(negedge clk) begin
    for (int i = expQ.size() - 1; i >= 0; i--) begin
      if (expQ[i].cyc == cyc) begin
        judge(expQ[i].fld, expQ[i].val, expQ[i].req);
        expQ.delete(i);
      end
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic kFeed(int n, int finalSync, string req);
    for (int i = 0; i < n; i++) begin
      kCharValid = 1'b1;
      pushExp(1, F_SYNC, (i == n - 1) ? finalSync : 0, req);
      step();
    end
    kCharValid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    {errCgsLoss, errFrameAlign, errLaneAlign} = '0;
    {swReinitReq, swRealignReq, hwReinitDisable} = '0;
    irqEnable = '0; statusClear = '0;
    kCharValid = 1'b0; cgsAchieved = 1'b1; sysrefIn = 1'b0;
    repeat (3) step();
    judge(F_SYNC, 1, "R1"); judge(F_IRQ, 0, "R1");
    judge(F_STAT, 0, "R1"); judge(F_STRB, 0, "R1");
    rstN = 1'b1;
    pushExp(1, F_SYNC, 1, "R1"); pushExp(1, F_STAT, 0, "R1");
    pushExp(1, F_IRQ, 0, "R1");  pushExp(1, F_STRB, 0, "R1");
    step(); step();

    // R2 R4 R6 R8: code-group lock loss, enabled interrupt
    irqEnable = 3'b001; errCgsLoss = 1'b1;
    pushExp(1, F_STAT, 1, "R4"); pushExp(1, F_SYNC, 0, "R2"); pushExp(2, F_IRQ, 1, "R6");
    step(); errCgsLoss = 1'b0; step();
    kFeed(4, 1, "R8");
    statusClear = 3'b001;
    pushExp(1, F_STAT, 0, "R5"); pushExp(2, F_IRQ, 0, "R6");
    step(); statusClear = '0; step();

    // R4 R6 R8: frame fault with masked irq, interrupted run
    errFrameAlign = 1'b1;
    pushExp(1, F_STAT, 2, "R4"); pushExp(1, F_SYNC, 0, "R2"); pushExp(2, F_IRQ, 0, "R6");
    step(); errFrameAlign = 1'b0; step();
    kFeed(2, 0, "R8");
    kCharValid = 1'b1; cgsAchieved = 1'b0; pushExp(1, F_SYNC, 0, "R8"); step();
    kCharValid = 1'b0; cgsAchieved = 1'b1; pushExp(1, F_SYNC, 0, "R8"); step();
    kFeed(4, 1, "R8");
    statusClear = 3'b010; pushExp(1, F_STAT, 0, "R5"); step(); statusClear = '0; step();

    // R5 set-and-clear collision, R10 fault on the closing character
    irqEnable = 3'b100; errLaneAlign = 1'b1; statusClear = 3'b100;
    pushExp(1, F_STAT, 4, "R5"); pushExp(1, F_SYNC, 0, "R2"); pushExp(2, F_IRQ, 1, "R6");
    step(); errLaneAlign = 1'b0; statusClear = '0; step();
    kFeed(3, 0, "R10");
    kCharValid = 1'b1; errLaneAlign = 1'b1; pushExp(1, F_SYNC, 0, "R10"); step();
    kCharValid = 1'b0; errLaneAlign = 1'b0;
    kFeed(4, 1, "R10");
    statusClear = 3'b100; pushExp(1, F_STAT, 0, "R5"); pushExp(2, F_IRQ, 0, "R6");
    step(); statusClear = '0; step();

    // R9: software request merges into an active run
    errFrameAlign = 1'b1; pushExp(1, F_SYNC, 0, "R2"); step(); errFrameAlign = 1'b0;
    kFeed(2, 0, "R9");
    kCharValid = 1'b1; swReinitReq = 1'b1; pushExp(1, F_SYNC, 0, "R9"); step();
    swReinitReq = 1'b0;
    kFeed(1, 1, "R9");
    statusClear = 3'b111; step(); statusClear = '0; step();

    // R3: faults logged but ignored for resynchronization
    hwReinitDisable = 1'b1; errCgsLoss = 1'b1;
    pushExp(1, F_STAT, 1, "R3"); pushExp(1, F_SYNC, 1, "R3"); pushExp(2, F_SYNC, 1, "R3");
    step(); errCgsLoss = 1'b0; step();
    errFrameAlign = 1'b1; errLaneAlign = 1'b1;
    pushExp(1, F_STAT, 7, "R3"); pushExp(1, F_SYNC, 1, "R3");
    step(); errFrameAlign = 1'b0; errLaneAlign = 1'b0; step();
    statusClear = 3'b111; pushExp(1, F_STAT, 0, "R5"); step(); statusClear = '0; step();

    // R7: software request while disabled and clean
    swReinitReq = 1'b1; pushExp(1, F_SYNC, 0, "R7"); pushExp(1, F_STAT, 0, "R7");
    step(); swReinitReq = 1'b0;
    kFeed(4, 1, "R7");

    // R11: realignment, SYSREF already high does not count
    hwReinitDisable = 1'b0; sysrefIn = 1'b1; step();
    swRealignReq = 1'b1;
    pushExp(1, F_STRB, 1, "R11"); pushExp(1, F_SYNC, 1, "R11");
    pushExp(2, F_STRB, 0, "R11"); pushExp(2, F_SYNC, 1, "R11");
    step(); swRealignReq = 1'b0; step();
    pushExp(1, F_SYNC, 1, "R11"); step();
    sysrefIn = 1'b0; pushExp(1, F_SYNC, 1, "R11"); step();
    sysrefIn = 1'b1; pushExp(1, F_SYNC, 0, "R11"); step();
    kFeed(4, 1, "R11");

    // R12: realignment request while busy is dropped
    swReinitReq = 1'b1; pushExp(1, F_SYNC, 0, "R7"); step(); swReinitReq = 1'b0;
    swRealignReq = 1'b1; pushExp(1, F_STRB, 0, "R12"); pushExp(2, F_STRB, 0, "R12");
    step(); swRealignReq = 1'b0;
    kFeed(4, 1, "R12");
    sysrefIn = 1'b0; step();
    sysrefIn = 1'b1; pushExp(1, F_SYNC, 1, "R12"); pushExp(2, F_SYNC, 1, "R12");
    step(); step(); step();

    while (expQ.size() != 0) step();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule